// File: doc/BRIEF.md
# Configuration Download Receiver

This block receives a one-time configuration load over a two-wire clock/data pair shortly after reset. The clock wire must first perform a timed handshake: it stays low for a minimum time after reset, rises inside an entry window, and then stays high for a bounded hold time. Only then does the block shift in an 80-bit package made of a 64-bit secret key, a configuration byte and a checksum byte.

The package is checked by adding its ten bytes modulo 256. If the sum is zero, the key and the decoded configuration fields are latched. The block then drives an acknowledge level for a fixed number of milliseconds and finally issues a single-cycle request to erase all learned transmitters. All timing is measured in millisecond ticks supplied by the surrounding chip. A bad handshake, an over-long clock phase or a checksum mismatch ends the download attempt for the rest of the reset period. Nothing is stored in any of these cases.

Top module: `cfgdl_rx`

## Requirements
- R1: Entry requires the synchronised clock wire to be low for at least ENTRY_LOW_MIN ms (default 1) after reset and to rise no later than ENTRY_WINDOW ms (default 64) after reset. A rise that comes too early, or no rise inside the window, means no package is ever accepted until the next reset.
- R2: After the entry rise, the clock wire must stay high for more than HOLD_MIN ms (default 8) and not more than HOLD_MAX ms (default 128) before it falls. Otherwise no package is accepted.
- R3: After the hold, data is sampled on each of 80 rising clock edges. Stream bit i is package bit i. Package bits 63:0 are the key, bits 71:64 are the configuration byte and bits 79:72 are the checksum. This is least significant byte first, and least significant bit first within each byte.
- R4: A package is accepted only if its ten bytes sum to zero modulo 256. On a mismatch there is no acknowledge and no erase request, and the stored key and configuration stay unchanged.
- R5: On acceptance, the stored key equals package bits 63:0. The configuration outputs decode the configuration byte as follows: bit 0 gives the XOR key algorithm (0 selects decrypt), bit 2 gives secure learn enable and bit 3 gives sleep enable. Bits 1 and 4 to 7 have no effect on any output.
- R6: After an accepted package, ack_drive goes high once and stays high for ACK_MS ms (default 4), measured in ticks.
- R7: erase_all pulses high for exactly one cycle, exactly once per accepted package, in the cycle right after ack_drive falls.
- R8: During the transfer, a clock phase, high or low, longer than PHASE_MAX ms (default 320) aborts it. There is then no acknowledge, no erase request and nothing is stored.
- R9: During and after reset the key is zero, all configuration outputs are low, and ack_drive and erase_all are low.
- R10: Only one download is possible per reset. After the attempt ends, further clock and data activity changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| prog_clk_in | input | 1 | Download clock wire (asynchronous) |
| prog_data_in | input | 1 | Download data wire (asynchronous) |
| mfr_key | output | 64 | Stored 64-bit key |
| cfg_alg_xor | output | 1 | Key algorithm select: 1 = XOR, 0 = decrypt |
| cfg_secure_learn | output | 1 | Secure learn enable |
| cfg_sleep_en | output | 1 | Sleep enable |
| erase_all | output | 1 | One-cycle request to erase all learned transmitters |
| ack_drive | output | 1 | High while the acknowledge level is driven onto the data wire |

## Verification
Sixteen packages sweep every value of the low configuration nibble, each paired with a different high nibble and an arithmetically generated key. Together they tell the decoded bits apart from the ignored ones and expose any byte or bit-order slip in the stored key. The worked checksum example and an off-by-one checksum separate the zero-sum acceptance from near misses. Handshake timings just inside and just outside the low, window and hold limits, together with a long but legal stall and an over-long stall in mid-transfer, tell the timing gates apart. A second package sent after a good one shows that the block takes only one download per reset.

// File: rtl/cfgdl_pkg.sv
package cfgdl_pkg;

    localparam int BYTE_W    = 8;
    localparam int KEY_W     = 64;
    localparam int CFG_ALG   = 0;
    localparam int CFG_SEC   = 2;
    localparam int CFG_SLEEP = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] csum;
        logic [BYTE_W-1:0] cfg;
        logic [KEY_W-1:0]  key;
    } dl_pkt_t;

    localparam int PKT_W  = $bits(dl_pkt_t);
    localparam int NBYTES = PKT_W / BYTE_W;

    typedef struct packed {
        logic sleep_en;
        logic secure_learn;
        logic alg_xor;
    } dl_cfg_t;

    typedef enum logic [2:0] {
        ST_WAIT, ST_HOLD, ST_SHIFT, ST_CHECK, ST_ACK, ST_ERASE, ST_DONE
    } dl_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic pkt_sum_zero(input logic [PKT_W-1:0] p);
        logic [BYTE_W-1:0] s;
        s = '0;
        for (int b = 0; b < NBYTES; b++) s = s + p[b*BYTE_W +: BYTE_W];
        return (s == '0);
    endfunction

    function automatic dl_cfg_t cfg_decode(input logic [BYTE_W-1:0] c);
        dl_cfg_t d;
        d.alg_xor      = c[CFG_ALG];
        d.secure_learn = c[CFG_SEC];
        d.sleep_en     = c[CFG_SLEEP];
        return d;
    endfunction

endpackage

// File: rtl/cfgdl_sync.sv
module cfgdl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_line,
    input  logic data_line,
    output logic clk_s,
    output logic data_s,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] dat_sh;
    logic              clk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sh <= '0;
            dat_sh <= '0;
            clk_d  <= 1'b0;
        end else begin
            clk_sh <= {clk_sh[STAGES-2:0], clk_line};
            dat_sh <= {dat_sh[STAGES-2:0], data_line};
            clk_d  <= clk_sh[STAGES-1];
        end
    end

    assign clk_s  = clk_sh[STAGES-1];
    assign data_s = dat_sh[STAGES-1];
    assign rise   = clk_s & ~clk_d;
    assign fall   = ~clk_s & clk_d;
endmodule

// File: rtl/cfgdl_shift.sv
module cfgdl_shift
    import cfgdl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    shift_en,
    input  logic    rise,
    input  logic    data_s,
    output dl_pkt_t pkt,
    output logic    full,
    output logic    sum_ok
);
    localparam int CW = $clog2(PKT_W + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PKT_W);

    logic [PKT_W-1:0] sr;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= '0;
        end else if (shift_en && rise && cnt != CNT_LAST) begin
            sr  <= {data_s, sr[PKT_W-1:1]};
            cnt <= cnt + 1'b1;
        end
    end

    assign pkt    = dl_pkt_t'(sr);
    assign full   = (cnt == CNT_LAST);
    assign sum_ok = pkt_sum_zero(sr);

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST);
    a_r3_shift_gated: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(cnt));
endmodule

// File: rtl/cfgdl_seq.sv
module cfgdl_seq
    import cfgdl_pkg::*;
#(
    parameter int ENTRY_LOW_MIN = 1,
    parameter int ENTRY_WINDOW  = 64,
    parameter int HOLD_MIN      = 8,
    parameter int HOLD_MAX      = 128,
    parameter int PHASE_MAX     = 320,
    parameter int ACK_MS        = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ms_tick,
    input  logic      line_lvl,
    input  logic      rise,
    input  logic      fall,
    input  logic      pkt_full,
    input  logic      sum_ok,
    output dl_state_t state,
    output logic      shift_en,
    output logic      commit,
    output logic      ack_on,
    output logic      erase_on
);
    localparam int TMAX = max_of(max_of(PHASE_MAX, HOLD_MAX), max_of(ENTRY_WINDOW, ACK_MS));
    localparam int TW   = $clog2(TMAX + 2);
    localparam logic [TW-1:0] L_LOW  = TW'(ENTRY_LOW_MIN);
    localparam logic [TW-1:0] L_WIN  = TW'(ENTRY_WINDOW);
    localparam logic [TW-1:0] L_HMIN = TW'(HOLD_MIN);
    localparam logic [TW-1:0] L_HMAX = TW'(HOLD_MAX);
    localparam logic [TW-1:0] L_PMAX = TW'(PHASE_MAX);
    localparam logic [TW-1:0] L_ACK  = TW'(ACK_MS);

    logic [TW-1:0] elapsed, low_ms, tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT;
            elapsed <= '0;
            low_ms  <= '0;
            tmr     <= '0;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (rise) begin
                        tmr   <= '0;
                        state <= (low_ms >= L_LOW && elapsed <= L_WIN) ? ST_HOLD : ST_DONE;
                    end else if (elapsed > L_WIN) begin
                        state <= ST_DONE;
                    end else if (ms_tick) begin
                        elapsed <= elapsed + 1'b1;
                        if (!line_lvl) low_ms <= low_ms + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (fall) begin
                        tmr   <= '0;
                        state <= (tmr > L_HMIN) ? ST_SHIFT : ST_DONE;
                    end else if (tmr > L_HMAX) begin
                        state <= ST_DONE;
                    end else if (ms_tick) begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (pkt_full)            state <= ST_CHECK;
                    else if (rise || fall)   tmr   <= '0;
                    else if (tmr > L_PMAX)   state <= ST_DONE;
                    else if (ms_tick)        tmr   <= tmr + 1'b1;
                end
                ST_CHECK: begin
                    tmr   <= '0;
                    state <= sum_ok ? ST_ACK : ST_DONE;
                end
                ST_ACK: begin
                    if (tmr >= L_ACK)  state <= ST_ERASE;
                    else if (ms_tick)  tmr   <= tmr + 1'b1;
                end
                ST_ERASE: state <= ST_DONE;
                default:  state <= ST_DONE;
            endcase
        end
    end

    assign shift_en = (state == ST_SHIFT);
    assign commit   = (state == ST_CHECK) && sum_ok;
    assign ack_on   = (state == ST_ACK);
    assign erase_on = (state == ST_ERASE);

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        state == ST_DONE |=> state == ST_DONE);
    a_r4_ack_needs_sum: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && $past(state) == ST_CHECK) |-> $past(sum_ok));
    a_r2_hold_long_enough: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && $past(state) == ST_HOLD) |-> $past(tmr) > L_HMIN);
    a_r8_phase_cap: assert property (@(posedge clk) disable iff (rst)
        state == ST_SHIFT |-> tmr <= L_PMAX + 1'b1);
endmodule

// File: rtl/cfgdl_rx.sv
module cfgdl_rx
    import cfgdl_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int ENTRY_LOW_MIN = 1,
    parameter int ENTRY_WINDOW  = 64,
    parameter int HOLD_MIN      = 8,
    parameter int HOLD_MAX      = 128,
    parameter int PHASE_MAX     = 320,
    parameter int ACK_MS        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              prog_clk_in,
    input  logic              prog_data_in,
    output logic [KEY_W-1:0]  mfr_key,
    output logic              cfg_alg_xor,
    output logic              cfg_secure_learn,
    output logic              cfg_sleep_en,
    output logic              erase_all,
    output logic              ack_drive
);
    logic      clk_s, data_s, rise, fall;
    logic      shift_en, commit, full, sum_ok;
    dl_state_t state;
    dl_pkt_t   pkt;
    logic [KEY_W-1:0] key_q;
    dl_cfg_t   cfg_q;

    cfgdl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .clk_line(prog_clk_in), .data_line(prog_data_in),
        .clk_s(clk_s), .data_s(data_s), .rise(rise), .fall(fall)
    );

    cfgdl_seq #(
        .ENTRY_LOW_MIN(ENTRY_LOW_MIN), .ENTRY_WINDOW(ENTRY_WINDOW),
        .HOLD_MIN(HOLD_MIN), .HOLD_MAX(HOLD_MAX),
        .PHASE_MAX(PHASE_MAX), .ACK_MS(ACK_MS)
    ) u_seq (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .line_lvl(clk_s),
        .rise(rise), .fall(fall), .pkt_full(full), .sum_ok(sum_ok),
        .state(state), .shift_en(shift_en), .commit(commit),
        .ack_on(ack_drive), .erase_on(erase_all)
    );

    cfgdl_shift u_shift (
        .clk(clk), .rst(rst), .shift_en(shift_en), .rise(rise), .data_s(data_s),
        .pkt(pkt), .full(full), .sum_ok(sum_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            cfg_q <= '0;
        end else if (commit) begin
            key_q <= pkt.key;
            cfg_q <= cfg_decode(pkt.cfg);
        end
    end

    assign mfr_key          = key_q;
    assign cfg_alg_xor      = cfg_q.alg_xor;
    assign cfg_secure_learn = cfg_q.secure_learn;
    assign cfg_sleep_en     = cfg_q.sleep_en;

    a_r7_erase_single: assert property (@(posedge clk) disable iff (rst)
        erase_all |=> !erase_all);
    a_r7_erase_after_ack: assert property (@(posedge clk) disable iff (rst)
        erase_all |-> $past(ack_drive));
    a_r5_store_with_ack: assert property (@(posedge clk) disable iff (rst)
        !$stable(key_q) |-> ack_drive);
    a_r6_ack_one_shot: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_drive) |-> erase_all);
endmodule

// File: tb/cfgdl_rx_tb.sv
module cfgdl_rx_tb;
    localparam int TICK_DIV = 8;
    localparam int ACK_MS   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_clk = 1'b0;
    logic prog_data = 1'b0;
    logic ms_tick;
    logic [63:0] mfr_key;
    logic cfg_alg_xor, cfg_secure_learn, cfg_sleep_en, erase_all, ack_drive;

    int tests = 0;
    int fails = 0;
    int div;
    int ack_cyc, erase_cnt;
    logic ack_prev, erase_bad;
    bit done_flag = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) div <= 0;
        else     div <= (div == TICK_DIV - 1) ? 0 : div + 1;
    end
    assign ms_tick = !rst && (div == TICK_DIV - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_cyc <= 0; erase_cnt <= 0; ack_prev <= 1'b0; erase_bad <= 1'b0;
        end else begin
            if (ack_drive) ack_cyc <= ack_cyc + 1;
            if (erase_all) begin
                erase_cnt <= erase_cnt + 1;
                if (!ack_prev) erase_bad <= 1'b1;
            end
            ack_prev <= ack_drive;
        end
    end

    cfgdl_rx u_dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick),
        .prog_clk_in(prog_clk), .prog_data_in(prog_data),
        .mfr_key(mfr_key), .cfg_alg_xor(cfg_alg_xor),
        .cfg_secure_learn(cfg_secure_learn), .cfg_sleep_en(cfg_sleep_en),
        .erase_all(erase_all), .ack_drive(ack_drive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_ms(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; prog_clk = 1'b0; prog_data = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic enter(input int low_ms, input int hold_ms);
        wait_ms(low_ms);
        prog_clk = 1'b1;
        wait_ms(hold_ms);
        prog_clk = 1'b0;
    endtask

    task automatic shift_pkt(input logic [79:0] p, input int stall_at, input int stall_ms);
        for (int i = 0; i < 80; i++) begin
            prog_data = p[i];
            wait_ms(1);
            if (i == stall_at) wait_ms(stall_ms);
            prog_clk = 1'b1;
            wait_ms(1);
            prog_clk = 1'b0;
        end
        prog_data = 1'b0;
        wait_ms(10);
    endtask

    function automatic logic [79:0] make_pkt(input logic [63:0] key, input logic [7:0] cfg,
                                             input logic [7:0] delta);
        logic [7:0] s;
        s = cfg;
        for (int b = 0; b < 8; b++) s = s + key[b*8 +: 8];
        return {8'(8'h00 - s + delta), cfg, key};
    endfunction

    task automatic expect_result(input bit accept, input logic [63:0] key, input logic [7:0] cfg,
                                 input string req);
        if (accept) begin
            chk(ack_cyc >= (ACK_MS - 1) * TICK_DIV + 1 && ack_cyc <= ACK_MS * TICK_DIV + 1,
                "R6", {req, " ack length"}, 64'(ack_cyc), 64'(ACK_MS * TICK_DIV));
            chk(erase_cnt == 1 && !erase_bad, "R7", {req, " erase pulse"},
                64'(erase_cnt), 64'd1);
            chk(mfr_key == key, "R3", {req, " key"}, mfr_key, key);
            chk({cfg_sleep_en, cfg_secure_learn, cfg_alg_xor} == {cfg[3], cfg[2], cfg[0]},
                "R5", {req, " cfg fields"},
                64'({cfg_sleep_en, cfg_secure_learn, cfg_alg_xor}),
                64'({cfg[3], cfg[2], cfg[0]}));
        end else begin
            chk(ack_cyc == 0 && erase_cnt == 0, req, "no ack/erase",
                64'(ack_cyc + erase_cnt), 64'd0);
            chk(mfr_key == 64'd0 && !cfg_alg_xor && !cfg_secure_learn && !cfg_sleep_en,
                req, "nothing stored",
                mfr_key | 64'({cfg_sleep_en, cfg_secure_learn, cfg_alg_xor}), 64'd0);
        end
    endtask

    task automatic run(input logic [63:0] key, input logic [7:0] cfg, input logic [7:0] delta,
                       input int low_ms, input int hold_ms, input int stall_at,
                       input int stall_ms, input bit accept, input string req);
        do_reset();
        enter(low_ms, hold_ms);
        shift_pkt(make_pkt(key, cfg, delta), stall_at, stall_ms);
        expect_result(accept, key, cfg, req);
    endtask

    initial begin
        // R9: reset state
        do_reset();
        @(negedge clk);
        chk(mfr_key == 0 && {cfg_alg_xor, cfg_secure_learn, cfg_sleep_en,
            erase_all, ack_drive} == 5'b0, "R9", "reset outputs",
            mfr_key | 64'({cfg_alg_xor, cfg_secure_learn, cfg_sleep_en, erase_all, ack_drive}),
            64'd0);

        // worked checksum example: sum byte 3F
        do_reset();
        enter(2, 12);
        shift_pkt({8'h3F, 8'h01, 64'h0123456789ABCDEF}, -1, 0);
        expect_result(1'b1, 64'h0123456789ABCDEF, 8'h01, "R4 example");

        // R5 / R3 sweep over the configuration nibble, high bits varied
        for (int i = 0; i < 16; i++) begin
            logic [63:0] k;
            logic [7:0]  c;
            k = {32'(32'h9E3779B9 * (i + 1)), 32'(32'h7F4A7C15 ^ (i * 32'h01010101))};
            c = {4'(15 - i), 4'(i)};
            run(k, c, 8'd0, 2, 12, -1, 0, 1'b1, "R5 sweep");
        end

        // R4 checksum off by one
        run(64'hA5A5_0F0F_1234_8765, 8'h0D, 8'd1, 2, 12, -1, 0, 1'b0, "R4");
        run(64'hA5A5_0F0F_1234_8765, 8'h0D, 8'hFF, 2, 12, -1, 0, 1'b0, "R4");

        // R1 entry timing
        run(64'h1111_2222_3333_4444, 8'h09, 8'd0, 0, 12, -1, 0, 1'b0, "R1");
        run(64'h1111_2222_3333_4444, 8'h09, 8'd0, 70, 12, -1, 0, 1'b0, "R1");
        run(64'h1111_2222_3333_4444, 8'h09, 8'd0, 60, 12, -1, 0, 1'b1, "R1 late ok");

        // R2 hold timing
        run(64'h5555_6666_7777_8888, 8'h04, 8'd0, 2, 6, -1, 0, 1'b0, "R2");
        run(64'h5555_6666_7777_8888, 8'h04, 8'd0, 2, 140, -1, 0, 1'b0, "R2");
        run(64'h5555_6666_7777_8888, 8'h04, 8'd0, 2, 120, -1, 0, 1'b1, "R2 long ok");

        // R8 phase limit
        run(64'hDEAD_BEEF_0BAD_F00D, 8'h08, 8'd0, 2, 12, 40, 330, 1'b0, "R8");
        run(64'hDEAD_BEEF_0BAD_F00D, 8'h08, 8'd0, 2, 12, 40, 100, 1'b1, "R8 stall ok");

        // R10 second package after an accepted one is ignored
        run(64'hCAFE_0000_1234_5678, 8'h05, 8'd0, 2, 12, -1, 0, 1'b1, "R10 first");
        enter(2, 12);
        shift_pkt(make_pkt(64'h0F0F_0F0F_0F0F_0F0F, 8'h0A, 8'd0), -1, 0);
        chk(mfr_key == 64'hCAFE_0000_1234_5678 && erase_cnt == 1 && cfg_alg_xor && cfg_secure_learn,
            "R10", "second package ignored", mfr_key, 64'hCAFE_0000_1234_5678);

        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done_flag) begin
            done_flag = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule